// File: doc/BRIEF.md
# Radio Operating-State Sequencer

This block owns the operating state of a packet radio. Software or other hardware sends one-cycle command pulses: enable transmit, enable receive, start, stop and disable. The block walks a fixed set of states in response. Each enable starts a ramp-up period, counted in clock cycles, whose length depends on a fast-ramp mode bit. When the ramp finishes, the radio waits in an idle state until it is started. The packet framer beside it reports two things: that an access address has passed, and that a whole packet has gone out or come in. The sequencer turns these reports into event flags.

Five event flags record what has happened: ready, address, payload, end and disabled. Each flag stays set until software writes a zero to it. An interrupt mask is changed through two separate vectors, one that sets mask bits and one that clears them. A single interrupt line reports any flag that is set and also enabled.

A shortcut register links events to commands without the processor. With it, a ramp-up can start a packet by itself, a finished packet can shut the radio down, and a completed shutdown can begin the next enable.

Top module: `radio_seq`

## Requirements
- R1: After a synchronous reset the state code is 0 (off), all event flags are clear, the interrupt mask is clear and the interrupt line is low.
- R2: The state codes are: off 0, receive ramp 1, receive idle 2, receive active 3, receive shutdown 4, transmit ramp 9, transmit idle 10, transmit active 11 and transmit shutdown 12. Transmit-enable in state 0 moves to 9. State 10 follows the ramp and raises the ready flag. Start moves state 10 to 11. An address-done pulse in state 11 raises the address flag. A packet-done pulse in state 11 returns to 10 and raises both the payload flag and the end flag.
- R3: Receive-enable in state 0 follows the same sequence through states 1, 2 and 3. Stop in state 3 (or 11) returns to the idle state without raising the end flag.
- R4: The ramp state lasts RAMP_SLOW cycles, or RAMP_FAST cycles when the fast-ramp input is high in the cycle the enable is accepted. The mode bit is sampled only at that moment.
- R5: Disable in any ramp, idle or active state moves to the shutdown state of the same direction (4 or 12). That state lasts OFF_CYCLES cycles, after which the block enters state 0 and raises the disabled flag.
- R6: A command that is not legal in the current state is ignored. This covers: enable outside state 0, start outside an idle state, disable in state 0 (no disabled flag is raised), and address-done or packet-done outside an active state.
- R7: The flag bits are ready 0, address 1, payload 2, end 3 and disabled 4. A flag becomes visible one cycle after the state change that raises it, and it stays set. When a write-enable bit is set, a write value of 0 clears that flag and a write value of 1 has no effect. If a new event and a clear reach the same flag in the same cycle, the event wins.
- R8: A 1 in the set vector enables that interrupt bit. A 1 in the clear vector disables it. Zeros in either vector have no effect. If both vectors carry a 1 for the same bit, the clear wins, so a clear vector of all ones masks every interrupt.
- R9: The interrupt line is the OR, over all five bits, of each flag ANDed with its mask bit. It updates in the same cycle as the flags and the mask.
- R10: The shortcut bits are: ready-to-start 0, end-to-disable 1, disabled-to-transmit-enable 2, disabled-to-receive-enable 3 and end-to-start 5. Bit 4 links nothing. A linked command acts in the cycle after its flag becomes visible. When both end-to-disable and end-to-start fire together, disable takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ramp_fast | input | 1 | Selects the short ramp when an enable is accepted |
| task_txen | input | 1 | Transmit-enable command pulse |
| task_rxen | input | 1 | Receive-enable command pulse |
| task_start | input | 1 | Start command pulse |
| task_stop | input | 1 | Stop command pulse |
| task_disable | input | 1 | Disable command pulse |
| addr_done | input | 1 | Framer: access address passed |
| pkt_done | input | 1 | Framer: packet finished |
| evt_wr_en | input | 5 | Per-flag write strobe |
| evt_wr_val | input | 5 | Per-flag write value (0 clears) |
| inten_set | input | 5 | Interrupt mask set vector |
| inten_clr | input | 5 | Interrupt mask clear vector |
| shorts_we | input | 1 | Shortcut register write strobe |
| shorts_wdata | input | 6 | Shortcut register write data |
| radio_state | output | 4 | Current state code |
| evt_flags | output | 5 | Sticky event flags |
| inten | output | 5 | Interrupt mask |
| irq | output | 1 | Interrupt request |

## Verification
Every state register is visible on the state code port, so a wrong transition shows up in the very next sampled cycle. A ramp or shutdown counter that is off by one moves the idle or off code by one cycle, and the directed sequences catch this by checking one cycle before and one cycle after each expected boundary. A lost or stray event appears one cycle after the transition, either as a flag value or as the interrupt line. A shortcut that fires on the wrong cycle, or fires the wrong command, changes the state code two cycles after the triggering transition.

// File: rtl/radio_seq_pkg.sv
package radio_seq_pkg;

  typedef enum logic [3:0] {
    ST_OFF      = 4'd0,
    ST_RX_RAMP  = 4'd1,
    ST_RX_IDLE  = 4'd2,
    ST_RX_RUN   = 4'd3,
    ST_RX_DOWN  = 4'd4,
    ST_TX_RAMP  = 4'd9,
    ST_TX_IDLE  = 4'd10,
    ST_TX_RUN   = 4'd11,
    ST_TX_DOWN  = 4'd12
  } rstate_e;

  localparam int EVW        = 5;
  localparam int EV_READY   = 0;
  localparam int EV_ADDR    = 1;
  localparam int EV_PAYLOAD = 2;
  localparam int EV_END     = 3;
  localparam int EV_OFF     = 4;

  localparam int SCW             = 6;
  localparam int SC_READY_START  = 0;
  localparam int SC_END_DISABLE  = 1;
  localparam int SC_OFF_TXEN     = 2;
  localparam int SC_OFF_RXEN     = 3;
  localparam int SC_END_START    = 5;

endpackage

// File: rtl/rs_state_fsm.sv
module rs_state_fsm
  import radio_seq_pkg::*;
#(
  parameter int RAMP_SLOW  = 24,
  parameter int RAMP_FAST  = 6,
  parameter int OFF_CYCLES = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ramp_fast,
  input  logic           go_txen,
  input  logic           go_rxen,
  input  logic           go_start,
  input  logic           go_stop,
  input  logic           go_disable,
  input  logic           addr_done,
  input  logic           pkt_done,
  output rstate_e        st_q,
  output logic [EVW-1:0] evt_pulse
);

  localparam int RAMP_MAX = (RAMP_SLOW > RAMP_FAST) ? RAMP_SLOW : RAMP_FAST;
  localparam int CNT_MAX  = (RAMP_MAX > OFF_CYCLES) ? RAMP_MAX : OFF_CYCLES;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] LIM_SLOW = CNT_W'(RAMP_SLOW - 1);
  localparam logic [CNT_W-1:0] LIM_FAST = CNT_W'(RAMP_FAST - 1);
  localparam logic [CNT_W-1:0] LIM_OFF  = CNT_W'(OFF_CYCLES - 1);

  rstate_e          st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic [EVW-1:0]   pulse_d;
  logic             is_tx;

  assign is_tx = st_q[3];

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    lim_d   = lim_q;
    pulse_d = '0;
    unique case (st_q)
      ST_OFF: begin
        if (go_txen || go_rxen) begin
          st_d  = go_txen ? ST_TX_RAMP : ST_RX_RAMP;
          cnt_d = '0;
          lim_d = ramp_fast ? LIM_FAST : LIM_SLOW;
        end
      end
      ST_TX_RAMP, ST_RX_RAMP: begin
        if (go_disable) begin
          st_d  = is_tx ? ST_TX_DOWN : ST_RX_DOWN;
          cnt_d = '0;
        end else if (cnt_q == lim_q) begin
          st_d = is_tx ? ST_TX_IDLE : ST_RX_IDLE;
          pulse_d[EV_READY] = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_TX_IDLE, ST_RX_IDLE: begin
        if (go_disable) begin
          st_d  = is_tx ? ST_TX_DOWN : ST_RX_DOWN;
          cnt_d = '0;
        end else if (go_start) begin
          st_d = is_tx ? ST_TX_RUN : ST_RX_RUN;
        end
      end
      ST_TX_RUN, ST_RX_RUN: begin
        if (go_disable) begin
          st_d  = is_tx ? ST_TX_DOWN : ST_RX_DOWN;
          cnt_d = '0;
        end else if (go_stop) begin
          st_d = is_tx ? ST_TX_IDLE : ST_RX_IDLE;
        end else begin
          if (addr_done) pulse_d[EV_ADDR] = 1'b1;
          if (pkt_done) begin
            st_d = is_tx ? ST_TX_IDLE : ST_RX_IDLE;
            pulse_d[EV_PAYLOAD] = 1'b1;
            pulse_d[EV_END]     = 1'b1;
          end
        end
      end
      ST_TX_DOWN, ST_RX_DOWN: begin
        if (cnt_q == LIM_OFF) begin
          st_d = ST_OFF;
          pulse_d[EV_OFF] = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_OFF;
      cnt_q     <= '0;
      lim_q     <= LIM_SLOW;
      evt_pulse <= '0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      lim_q     <= lim_d;
      evt_pulse <= pulse_d;
    end
  end

  assert_state_code_R2: assert property (@(posedge clk) disable iff (rst)
    st_q inside {ST_OFF, ST_RX_RAMP, ST_RX_IDLE, ST_RX_RUN, ST_RX_DOWN,
                 ST_TX_RAMP, ST_TX_IDLE, ST_TX_RUN, ST_TX_DOWN});

  assert_ramp_entry_R6: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_TX_RAMP || st_q == ST_RX_RAMP) && $past(st_q) != st_q)
      |-> $past(st_q) == ST_OFF);

  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (rst)
    evt_pulse[EV_READY] |-> (st_q == ST_TX_IDLE || st_q == ST_RX_IDLE));

  assert_ramp_count_R4: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_TX_RAMP || st_q == ST_RX_RAMP) |-> cnt_q <= lim_q);

  assert_disable_exit_R5: assert property (@(posedge clk) disable iff (rst)
    (go_disable && !(st_q inside {ST_OFF, ST_TX_DOWN, ST_RX_DOWN}))
      |=> (st_q == ST_TX_DOWN || st_q == ST_RX_DOWN));

endmodule

// File: rtl/rs_event_bank.sv
module rs_event_bank
  import radio_seq_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [EVW-1:0] evt_pulse,
  input  logic [EVW-1:0] wr_en,
  input  logic [EVW-1:0] wr_val,
  input  logic [EVW-1:0] set_vec,
  input  logic [EVW-1:0] clr_vec,
  output logic [EVW-1:0] flags_q,
  output logic [EVW-1:0] mask_q,
  output logic           irq_q
);

  logic [EVW-1:0] flags_d;
  logic [EVW-1:0] mask_d;

  always_comb begin
    for (int i = 0; i < EVW; i++) begin
      flags_d[i] = flags_q[i];
      if (wr_en[i] && !wr_val[i]) flags_d[i] = 1'b0;
      if (evt_pulse[i])           flags_d[i] = 1'b1;
    end
    mask_d = (mask_q | set_vec) & ~clr_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      mask_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      mask_q  <= mask_d;
      irq_q   <= |(flags_d & mask_d);
    end
  end

  for (genvar g = 0; g < EVW; g++) begin : g_sticky
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      (flags_q[g] && !(wr_en[g] && !wr_val[g])) |=> flags_q[g]);
  end

  assert_mask_clear_all_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_vec == '1) |=> (mask_q == '0));

  assert_irq_or_R9: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(flags_q & mask_q));

endmodule

// File: rtl/rs_shortcut.sv
module rs_shortcut
  import radio_seq_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           sh_we,
  input  logic [SCW-1:0] sh_wdata,
  input  logic [EVW-1:0] evt_pulse,
  output logic           sc_txen,
  output logic           sc_rxen,
  output logic           sc_start,
  output logic           sc_disable
);

  logic [SCW-1:0] link_q;
  logic           rsvd_unused;

  assign rsvd_unused = link_q[4];

  always_ff @(posedge clk) begin
    if (rst) begin
      link_q     <= '0;
      sc_txen    <= 1'b0;
      sc_rxen    <= 1'b0;
      sc_start   <= 1'b0;
      sc_disable <= 1'b0;
    end else begin
      if (sh_we) link_q <= sh_wdata;
      sc_start   <= (evt_pulse[EV_READY] && link_q[SC_READY_START])
                  || (evt_pulse[EV_END] && link_q[SC_END_START]);
      sc_disable <= evt_pulse[EV_END] && link_q[SC_END_DISABLE];
      sc_txen    <= evt_pulse[EV_OFF] && link_q[SC_OFF_TXEN];
      sc_rxen    <= evt_pulse[EV_OFF] && link_q[SC_OFF_RXEN];
    end
  end

  assert_ready_link_R10: assert property (@(posedge clk) disable iff (rst)
    (evt_pulse[EV_READY] && link_q[SC_READY_START]) |=> sc_start);

  assert_off_link_R10: assert property (@(posedge clk) disable iff (rst)
    (sc_txen || sc_rxen) |-> $past(evt_pulse[EV_OFF]));

endmodule

// File: rtl/radio_seq.sv
module radio_seq
  import radio_seq_pkg::*;
#(
  parameter int RAMP_SLOW  = 24,
  parameter int RAMP_FAST  = 6,
  parameter int OFF_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ramp_fast,
  input  logic       task_txen,
  input  logic       task_rxen,
  input  logic       task_start,
  input  logic       task_stop,
  input  logic       task_disable,
  input  logic       addr_done,
  input  logic       pkt_done,
  input  logic [4:0] evt_wr_en,
  input  logic [4:0] evt_wr_val,
  input  logic [4:0] inten_set,
  input  logic [4:0] inten_clr,
  input  logic       shorts_we,
  input  logic [5:0] shorts_wdata,
  output logic [3:0] radio_state,
  output logic [4:0] evt_flags,
  output logic [4:0] inten,
  output logic       irq
);

  rstate_e        st;
  logic [EVW-1:0] pulse;
  logic           sc_txen, sc_rxen, sc_start, sc_disable;

  rs_state_fsm #(
    .RAMP_SLOW (RAMP_SLOW),
    .RAMP_FAST (RAMP_FAST),
    .OFF_CYCLES(OFF_CYCLES)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .ramp_fast (ramp_fast),
    .go_txen   (task_txen | sc_txen),
    .go_rxen   (task_rxen | sc_rxen),
    .go_start  (task_start | sc_start),
    .go_stop   (task_stop),
    .go_disable(task_disable | sc_disable),
    .addr_done (addr_done),
    .pkt_done  (pkt_done),
    .st_q      (st),
    .evt_pulse (pulse)
  );

  rs_shortcut u_sc (
    .clk       (clk),
    .rst       (rst),
    .sh_we     (shorts_we),
    .sh_wdata  (shorts_wdata),
    .evt_pulse (pulse),
    .sc_txen   (sc_txen),
    .sc_rxen   (sc_rxen),
    .sc_start  (sc_start),
    .sc_disable(sc_disable)
  );

  rs_event_bank u_evt (
    .clk      (clk),
    .rst      (rst),
    .evt_pulse(pulse),
    .wr_en    (evt_wr_en),
    .wr_val   (evt_wr_val),
    .set_vec  (inten_set),
    .clr_vec  (inten_clr),
    .flags_q  (evt_flags),
    .mask_q   (inten),
    .irq_q    (irq)
  );

  assign radio_state = st;

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (radio_state == 4'd0 && evt_flags == '0 && !irq));

endmodule

// File: tb/radio_seq_test.sv
`timescale 1ns/1ps
module radio_seq_test;

  localparam int RS = 24;
  localparam int RF = 6;
  localparam int DC = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ramp_fast = 1'b0;
  logic task_txen = 0, task_rxen = 0, task_start = 0, task_stop = 0, task_disable = 0;
  logic addr_done = 0, pkt_done = 0;
  logic [4:0] evt_wr_en = '0, evt_wr_val = '0, inten_set = '0, inten_clr = '0;
  logic shorts_we = 0;
  logic [5:0] shorts_wdata = '0;
  logic [3:0] radio_state;
  logic [4:0] evt_flags, inten;
  logic irq;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  radio_seq #(.RAMP_SLOW(RS), .RAMP_FAST(RF), .OFF_CYCLES(DC)) uut (
    .clk(clk), .rst(rst), .ramp_fast(ramp_fast),
    .task_txen(task_txen), .task_rxen(task_rxen), .task_start(task_start),
    .task_stop(task_stop), .task_disable(task_disable),
    .addr_done(addr_done), .pkt_done(pkt_done),
    .evt_wr_en(evt_wr_en), .evt_wr_val(evt_wr_val),
    .inten_set(inten_set), .inten_clr(inten_clr),
    .shorts_we(shorts_we), .shorts_wdata(shorts_wdata),
    .radio_state(radio_state), .evt_flags(evt_flags), .inten(inten), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // 0 txen, 1 rxen, 2 start, 3 stop, 4 disable, 5 addr_done, 6 pkt_done
  task automatic pulse(input int which);
    case (which)
      0: task_txen = 1; 1: task_rxen = 1; 2: task_start = 1; 3: task_stop = 1;
      4: task_disable = 1; 5: addr_done = 1; default: pkt_done = 1;
    endcase
    tick(1);
    task_txen = 0; task_rxen = 0; task_start = 0; task_stop = 0;
    task_disable = 0; addr_done = 0; pkt_done = 0;
  endtask

  task automatic clr_flags();
    evt_wr_en = '1; evt_wr_val = '0; tick(1);
    evt_wr_en = '0;
  endtask

  task automatic t_reset();
    chk("R1 state", radio_state, 0);
    chk("R1 flags", evt_flags, 0);
    chk("R1 mask", inten, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_tx_flow();
    pulse(0);
    chk("R2 tx ramp code", radio_state, 9);
    tick(RS - 1);
    chk("R4 slow ramp last cycle", radio_state, 9);
    tick(1);
    chk("R2 tx idle code", radio_state, 10);
    chk("R7 ready not yet visible", evt_flags, 0);
    tick(1);
    chk("R7 ready flag", evt_flags, 5'b00001);
    pulse(5);
    pulse(6);
    tick(1);
    chk("R6 framer pulses ignored in idle", evt_flags, 5'b00001);
    pulse(0);
    chk("R6 txen ignored in idle", radio_state, 10);
    pulse(2);
    chk("R2 tx run code", radio_state, 11);
    pulse(5);
    tick(1);
    chk("R2 address flag", evt_flags, 5'b00011);
    pulse(6);
    chk("R2 packet back to idle", radio_state, 10);
    tick(1);
    chk("R2 payload and end flags", evt_flags, 5'b01111);
    clr_flags();
    chk("R7 clear by zero write", evt_flags, 0);
    pulse(4);
    chk("R5 tx shutdown code", radio_state, 12);
    tick(DC - 1);
    chk("R5 shutdown last cycle", radio_state, 12);
    tick(1);
    chk("R5 off reached", radio_state, 0);
    tick(1);
    chk("R5 disabled flag", evt_flags, 5'b10000);
    clr_flags();
    pulse(4);
    chk("R6 disable in off keeps state", radio_state, 0);
    tick(1);
    chk("R6 disable in off raises nothing", evt_flags, 0);
    pulse(2);
    chk("R6 start in off ignored", radio_state, 0);
  endtask

  task automatic t_rx_fast();
    ramp_fast = 1;
    pulse(1);
    ramp_fast = 0;
    chk("R3 rx ramp code", radio_state, 1);
    tick(RF - 1);
    chk("R4 fast ramp last cycle", radio_state, 1);
    tick(1);
    chk("R4 fast ramp done", radio_state, 2);
    tick(1);
    chk("R3 ready flag", evt_flags, 5'b00001);
    pulse(2);
    chk("R3 rx run code", radio_state, 3);
    pulse(3);
    chk("R3 stop returns idle", radio_state, 2);
    tick(1);
    chk("R3 stop raises no end", evt_flags, 5'b00001);
    pulse(4);
    chk("R5 rx shutdown code", radio_state, 4);
    tick(DC);
    chk("R5 rx off", radio_state, 0);
    tick(1);
    clr_flags();
  endtask

  task automatic t_flag_write();
    pulse(0);
    pulse(4);
    chk("R5 disable during ramp", radio_state, 12);
    tick(DC);
    chk("R5 off after ramp abort", radio_state, 0);
    evt_wr_en = 5'b10000; evt_wr_val = 5'b00000; tick(1);
    evt_wr_en = '0;
    chk("R7 event wins over clear", evt_flags, 5'b10000);
    evt_wr_en = 5'b10000; evt_wr_val = 5'b10000; tick(1);
    evt_wr_en = '0; evt_wr_val = '0;
    chk("R7 write of one ignored", evt_flags, 5'b10000);
  endtask

  task automatic t_mask();
    chk("R9 irq low while masked", irq, 0);
    inten_set = 5'b10000; tick(1); inten_set = '0;
    chk("R8 set bit", inten, 5'b10000);
    chk("R9 irq high", irq, 1);
    inten_set = 5'b00001; inten_clr = 5'b00000; tick(1); inten_set = '0;
    chk("R8 zeros no effect", inten, 5'b10001);
    inten_set = 5'b10000; inten_clr = 5'b10000; tick(1);
    inten_set = '0; inten_clr = '0;
    chk("R8 clear wins", inten, 5'b00001);
    chk("R9 irq drops", irq, 0);
    inten_set = '1; tick(1); inten_set = '0;
    chk("R8 set all", inten, 5'b11111);
    inten_clr = '1; tick(1); inten_clr = '0;
    chk("R8 clear all", inten, 0);
    clr_flags();
    chk("R7 flag cleared", evt_flags, 0);
  endtask

  task automatic t_shortcut();
    shorts_wdata = 6'b111011; shorts_we = 1; tick(1); shorts_we = 0;
    pulse(0);
    tick(RS);
    chk("R10 idle before link", radio_state, 10);
    tick(1);
    chk("R10 still idle on flag cycle", radio_state, 10);
    tick(1);
    chk("R10 ready-to-start", radio_state, 11);
    pulse(6);
    chk("R10 packet done idle", radio_state, 10);
    tick(1);
    chk("R10 end flag cycle", radio_state, 10);
    tick(1);
    chk("R10 disable beats start", radio_state, 12);
    tick(DC);
    chk("R10 off", radio_state, 0);
    tick(1);
    chk("R10 off flag cycle", radio_state, 0);
    tick(1);
    chk("R10 disabled-to-rxen", radio_state, 1);
    shorts_wdata = '0; shorts_we = 1; tick(1); shorts_we = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tick(4);
    rst = 0;
    tick(1);
    t_reset();
    t_tx_flow();
    t_rx_fast();
    t_flag_write();
    t_mask();
    t_shortcut();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule